// File: doc/BRIEF.md
# Paged Bank Address Translator

This block turns a 5-bit instruction operand into a 7-bit physical word address for a single-port 32-bit data RAM. The RAM holds nine banks. Each bank is 256 bits wide and spans eight words. An instruction never names a bank directly. It names one of four slots in the active page. A fixed table maps each of the four pages to four banks, and those banks need not be contiguous. Page commands change the active page. The active page is held as a small state machine with states `PAGE0`, `PAGE1`, `PAGE2` and `PAGE3`. On every clock the machine takes one of four transitions: `HOLD`, `SELECT`, `INC` or `DEC`.

A registered swap bit exchanges the physical numbers of two designated scratch banks. This replaces a data-moving conditional swap in a ladder-style computation. Translation uses the same mux path whether the bit is 0 or 1, so timing does not depend on the secret bit. A separate host port may reach only banks 0 and 1. The block strips the write enable from any other host access and forces the read data to zero.

Top module: `bank_addr_unit`

## Requirements
- R1: After reset the active page is 0 and the swap bit is 0.
- R2: Page command 2'b01 (`SELECT`) loads `pg_sel` as the active page at the next clock edge.
- R3: Page command 2'b10 (`INC`) advances the page by one at the next edge, wrapping from 3 to 0.
- R4: Page command 2'b11 (`DEC`) lowers the page by one at the next edge, wrapping from 0 to 3.
- R5: Page command 2'b00 (`HOLD`) leaves the active page unchanged.
- R6: With the swap bit 0, `opnd_addr` is {bank, opnd[2:0]} where bank comes from `opnd[4:3]` (the slot) and the active page through this table: page0 = 0,1,2,3; page1 = 2,4,5,6; page2 = 3,7,8,4; page3 = 5,1,6,8 (slot 0 first).
- R7: `swap_wr` loads `swap_val` into the swap bit at the next edge. While the bit is 1, bank 5 translates to 6 and bank 6 to 5, and all other banks are unchanged.
- R8: A host access whose bank number is 2 or above gives `host_ram_we` = 0 and `host_denied` = 1 whatever `host_we` is.
- R9: A host access to a bank number of 2 or above reads `host_rdata` = 0. Banks 0 and 1 pass `ram_rdata` and `host_we` through unchanged with `host_denied` = 0.
- R10: The translation has no register stage. `opnd_addr` follows a change of `opnd` within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pg_cmd | input | 2 | Page command: 00 hold, 01 select, 10 increment, 11 decrement |
| pg_sel | input | 2 | Page number for the select command |
| swap_wr | input | 1 | Load strobe for the swap bit |
| swap_val | input | 1 | New swap bit value |
| opnd | input | 5 | Operand: slot in [4:3], word in [2:0] |
| opnd_addr | output | 7 | Physical word address: bank in [6:3], word in [2:0] |
| cur_page | output | 2 | Active page |
| host_bank | input | 4 | Bank number of the host access |
| host_we | input | 1 | Host write request |
| ram_rdata | input | 32 | Read data from the RAM |
| host_ram_we | output | 1 | Gated write enable toward the RAM |
| host_rdata | output | 32 | Gated read data toward the host |
| host_denied | output | 1 | High when the host access is blocked |

## Verification
A wrong page state shows at `cur_page` one cycle after the command that caused it. Every later operand translation also lands in the wrong bank, so a single operand sample after each command exposes it. A stuck or inverted swap bit shows up only on operands whose slot maps to bank 5 or 6. The sweeps therefore cover every page, slot and word with the bit both clear and set. A gating fault appears in the same cycle on `host_ram_we` or `host_rdata` for banks 2 to 15.

// File: rtl/bank_addr_pkg.sv
package bank_addr_pkg;
    localparam int NUM_PAGES = 4;
    localparam int PAGE_W    = 2;
    localparam int SLOT_W    = 2;
    localparam int BANK_W    = 4;

    typedef enum logic [1:0] {
        CMD_HOLD   = 2'b00,
        CMD_SELECT = 2'b01,
        CMD_INC    = 2'b10,
        CMD_DEC    = 2'b11
    } page_cmd_e;

    typedef enum logic [PAGE_W-1:0] {
        PAGE0 = 2'd0,
        PAGE1 = 2'd1,
        PAGE2 = 2'd2,
        PAGE3 = 2'd3
    } page_e;

    // Fixed page-to-bank map, four slots per page.
    function automatic logic [BANK_W-1:0] page_bank(input logic [PAGE_W-1:0] pg,
                                                    input logic [SLOT_W-1:0] slot);
        logic [BANK_W-1:0] b;
        unique case ({pg, slot})
            4'h0: b = 4'd0;  4'h1: b = 4'd1;  4'h2: b = 4'd2;  4'h3: b = 4'd3;
            4'h4: b = 4'd2;  4'h5: b = 4'd4;  4'h6: b = 4'd5;  4'h7: b = 4'd6;
            4'h8: b = 4'd3;  4'h9: b = 4'd7;  4'hA: b = 4'd8;  4'hB: b = 4'd4;
            default: b = 4'd0;
        endcase
        if (pg == 2'd3) begin
            unique case (slot)
                2'd0: b = 4'd5;
                2'd1: b = 4'd1;
                2'd2: b = 4'd6;
                default: b = 4'd8;
            endcase
        end
        return b;
    endfunction
endpackage

// File: rtl/page_fsm.sv
module page_fsm
    import bank_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [PAGE_W-1:0] sel_i,
    output logic [PAGE_W-1:0] page_o
);
    page_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAGE0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (page_cmd_e'(cmd_i))
            CMD_HOLD:   state_d = state_q;
            CMD_SELECT: state_d = page_e'(sel_i);
            CMD_INC:    state_d = page_e'(PAGE_W'(state_q + 2'd1));
            CMD_DEC:    state_d = page_e'(PAGE_W'(state_q - 2'd1));
            default:    state_d = state_q;
        endcase
    end

    always_comb begin
        page_o = state_q;
    end

    p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 2'b01 |=> page_o == $past(sel_i));
    p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 2'b10 |=> page_o == PAGE_W'($past(page_o) + 2'd1));
    p_dec_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 2'b11 |=> page_o == PAGE_W'($past(page_o) - 2'd1));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_i == 2'b00 |=> $stable(page_o));
endmodule

// File: rtl/swap_reg.sv
module swap_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  logic val_i,
    output logic swap_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    swap_o <= 1'b0;
        else if (wr_i) swap_o <= val_i;
    end

    p_swap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> swap_o == $past(val_i));
    p_swap_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(swap_o));
endmodule

// File: rtl/addr_xlat.sv
module addr_xlat
    import bank_addr_pkg::*;
#(
    parameter int NUM_BANKS = 9,
    parameter int WORD_W    = 3,
    parameter int SWAP_A    = 5,
    parameter int SWAP_B    = 6
) (
    input  logic [PAGE_W-1:0]        page_i,
    input  logic                     swap_i,
    input  logic [SLOT_W+WORD_W-1:0] opnd_i,
    output logic [BANK_W+WORD_W-1:0] addr_o
);
    localparam logic [BANK_W-1:0] BA = BANK_W'(SWAP_A);
    localparam logic [BANK_W-1:0] BB = BANK_W'(SWAP_B);

    logic [BANK_W-1:0] raw_bank, phys_bank;

    always_comb begin
        raw_bank = page_bank(page_i, opnd_i[SLOT_W+WORD_W-1:WORD_W]);
        // Both candidates formed every time; the bit only steers the mux.
        phys_bank = raw_bank;
        if (raw_bank == BA) phys_bank = swap_i ? BB : BA;
        if (raw_bank == BB) phys_bank = swap_i ? BA : BB;
        addr_o = {phys_bank, opnd_i[WORD_W-1:0]};
    end

    always_comb begin
        p_bank_range_r6: assert (addr_o[BANK_W+WORD_W-1:WORD_W] < BANK_W'(NUM_BANKS));
        p_word_kept_r10: assert (addr_o[WORD_W-1:0] == opnd_i[WORD_W-1:0]);
    end
endmodule

// File: rtl/host_gate.sv
module host_gate #(
    parameter int BANK_W    = 4,
    parameter int DATA_W    = 32,
    parameter int USER_BANKS = 2
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] ram_rdata_i,
    output logic              ram_we_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              denied_o
);
    logic ok;

    always_comb begin
        ok       = bank_i < BANK_W'(USER_BANKS);
        denied_o = !ok;
        ram_we_o = we_i && ok;
        rdata_o  = ok ? ram_rdata_i : '0;
    end

    always_comb begin
        if (bank_i >= BANK_W'(USER_BANKS)) begin
            p_no_write_r8: assert (!ram_we_o);
            p_zero_read_r9: assert (rdata_o == '0);
        end
    end
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
    import bank_addr_pkg::*;
#(
    parameter int NUM_BANKS  = 9,
    parameter int WORD_W     = 3,
    parameter int DATA_W     = 32,
    parameter int USER_BANKS = 2,
    parameter int SWAP_A     = 5,
    parameter int SWAP_B     = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               pg_cmd,
    input  logic [PAGE_W-1:0]        pg_sel,
    input  logic                     swap_wr,
    input  logic                     swap_val,
    input  logic [SLOT_W+WORD_W-1:0] opnd,
    output logic [BANK_W+WORD_W-1:0] opnd_addr,
    output logic [PAGE_W-1:0]        cur_page,
    input  logic [BANK_W-1:0]        host_bank,
    input  logic                     host_we,
    input  logic [DATA_W-1:0]        ram_rdata,
    output logic                     host_ram_we,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     host_denied
);
    logic swap_q;

    page_fsm u_page (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd_i (pg_cmd),
        .sel_i (pg_sel),
        .page_o(cur_page)
    );

    swap_reg u_swap (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (swap_wr),
        .val_i (swap_val),
        .swap_o(swap_q)
    );

    addr_xlat #(
        .NUM_BANKS(NUM_BANKS), .WORD_W(WORD_W), .SWAP_A(SWAP_A), .SWAP_B(SWAP_B)
    ) u_xlat (
        .page_i(cur_page),
        .swap_i(swap_q),
        .opnd_i(opnd),
        .addr_o(opnd_addr)
    );

    host_gate #(
        .BANK_W(BANK_W), .DATA_W(DATA_W), .USER_BANKS(USER_BANKS)
    ) u_gate (
        .bank_i     (host_bank),
        .we_i       (host_we),
        .ram_rdata_i(ram_rdata),
        .ram_we_o   (host_ram_we),
        .rdata_o    (host_rdata),
        .denied_o   (host_denied)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (cur_page == 2'd0) || $rose(rst_n));
endmodule

// File: tb/tb_bank_addr_unit.sv
`timescale 1ns/100ps
module tb_bank_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pg_cmd = 2'b00;
    logic [1:0]  pg_sel = 2'b00;
    logic        swap_wr = 1'b0;
    logic        swap_val = 1'b0;
    logic [4:0]  opnd = 5'd0;
    logic [6:0]  opnd_addr;
    logic [1:0]  cur_page;
    logic [3:0]  host_bank = 4'd0;
    logic        host_we = 1'b0;
    logic [31:0] ram_rdata = 32'd0;
    logic        host_ram_we;
    logic [31:0] host_rdata;
    logic        host_denied;

    int checks = 0;
    int failures = 0;
    logic [1:0] m_page = 2'd0;
    logic       m_swap = 1'b0;

    always #2.5 clk = ~clk;

    bank_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .pg_cmd(pg_cmd), .pg_sel(pg_sel),
        .swap_wr(swap_wr), .swap_val(swap_val), .opnd(opnd),
        .opnd_addr(opnd_addr), .cur_page(cur_page), .host_bank(host_bank),
        .host_we(host_we), .ram_rdata(ram_rdata), .host_ram_we(host_ram_we),
        .host_rdata(host_rdata), .host_denied(host_denied)
    );

    function automatic logic [3:0] ref_bank(input logic [1:0] pg, input logic [1:0] sl,
                                            input logic sw);
        logic [3:0] row [4];
        logic [3:0] b;
        case (pg)
            2'd0: begin row[0]=0; row[1]=1; row[2]=2; row[3]=3; end
            2'd1: begin row[0]=2; row[1]=4; row[2]=5; row[3]=6; end
            2'd2: begin row[0]=3; row[1]=7; row[2]=8; row[3]=4; end
            default: begin row[0]=5; row[1]=1; row[2]=6; row[3]=8; end
        endcase
        b = row[sl];
        if (sw && b == 4'd5)      b = 4'd6;
        else if (sw && b == 4'd6) b = 4'd5;
        return b;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply commands at negedge; they take effect at the next posedge.
    task automatic cycle(input logic [1:0] c, input logic [1:0] s,
                         input logic w, input logic v);
        @(negedge clk);
        pg_cmd = c; pg_sel = s; swap_wr = w; swap_val = v;
        case (c)
            2'b01: m_page = s;
            2'b10: m_page = m_page + 2'd1;
            2'b11: m_page = m_page - 2'd1;
            default: ;
        endcase
        if (w) m_swap = v;
        @(posedge clk); #1;
        pg_cmd = 2'b00; swap_wr = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int sl = 0; sl < 4; sl++) begin
            for (int wd = 0; wd < 8; wd++) begin
                opnd = {2'(sl), 3'(wd)}; #0.2;
                check(req, 32'(opnd_addr), 32'({ref_bank(m_page, 2'(sl), m_swap), 3'(wd)}));
            end
        end
    endtask

    initial begin
        #100000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0007));
        repeat (3) @(posedge clk);
        #1;
        check("R1 page", 32'(cur_page), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 page after release", 32'(cur_page), 0);
        sweep("R1 swap clear");

        // R6 and R7: every page, slot, word, both swap settings
        for (int sw = 0; sw < 2; sw++) begin
            cycle(2'b00, 2'b00, 1'b1, 1'(sw));
            for (int pg = 0; pg < 4; pg++) begin
                cycle(2'b01, 2'(pg), 1'b0, 1'b0);
                check("R2 select", 32'(cur_page), 32'(pg));
                sweep(sw == 0 ? "R6 map" : "R7 swap map");
            end
        end

        // R3 and R4 wrap corners
        cycle(2'b01, 2'd3, 1'b0, 1'b0);
        cycle(2'b10, 2'd0, 1'b0, 1'b0);
        check("R3 inc wrap", 32'(cur_page), 0);
        cycle(2'b11, 2'd0, 1'b0, 1'b0);
        check("R4 dec wrap", 32'(cur_page), 3);
        cycle(2'b00, 2'd1, 1'b0, 1'b0);
        check("R5 hold", 32'(cur_page), 3);

        // R10: operand change seen in the same cycle
        @(negedge clk);
        opnd = 5'b10_101; #0.2;
        check("R10 same cycle", 32'(opnd_addr), 32'({ref_bank(m_page, 2'd2, m_swap), 3'd5}));

        // Random command mix
        for (int i = 0; i < 400; i++) begin
            cycle(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            check("R2 R3 R4 R5 page", 32'(cur_page), 32'(m_page));
            opnd = 5'($urandom_range(0, 31)); #0.2;
            check("R6 R7 random addr", 32'(opnd_addr),
                  32'({ref_bank(m_page, opnd[4:3], m_swap), opnd[2:0]}));
        end

        // R8 and R9: host gating over every bank number
        for (int b = 0; b < 16; b++) begin
            for (int w = 0; w < 2; w++) begin
                @(negedge clk);
                host_bank = 4'(b); host_we = 1'(w); ram_rdata = $urandom; #0.2;
                if (b < 2) begin
                    check("R9 user we", 32'(host_ram_we), 32'(w));
                    check("R9 user rdata", host_rdata, ram_rdata);
                    check("R9 user allowed", 32'(host_denied), 0);
                end else begin
                    check("R8 blocked we", 32'(host_ram_we), 0);
                    check("R8 denied", 32'(host_denied), 1);
                    check("R9 zero rdata", host_rdata, 0);
                end
            end
        end

        // R1 again: reset mid-run clears page and swap
        cycle(2'b01, 2'd2, 1'b1, 1'b1);
        @(negedge clk); rst_n = 1'b0; m_page = 2'd0; m_swap = 1'b0;
        @(posedge clk); #1;
        check("R1 page on reset", 32'(cur_page), 0);
        @(negedge clk); rst_n = 1'b1;
        sweep("R1 swap cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule